// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between a UART and an infrared transceiver and converts between the UART's NRZ serial levels and short-pulse infrared signalling. All timing is counted in ticks of a 16x oversampling clock enable (`tick16`) that pulses for one `clk` cycle per sixteenth of a bit. On the transmit side, the UART marks the start of every bit with a strobe. Each zero bit becomes a single high pulse three ticks wide, placed in the middle of the bit. A one bit produces no pulse, and the line rests low between pulses.

On the receive side, the raw infrared input can be inverted first, for receiver modules that report light as a low level. The decoder samples it on every tick. A sampled high level pulls the NRZ output low at that tick, and the output stays low until a full bit period of ticks has passed with no further high sample. That NRZ stream then feeds the UART receiver.

A single mode input switches both directions at once. With IR mode off, the transmit and receive levels pass straight through, and every bit-phase and hold counter is kept cleared. Turning IR mode back on therefore starts from the idle state.

Top module: `irsir_codec`

## Requirements
- R1: In IR mode, a bit strobed with `tx_nrz`=0 drives `tx_out` high for exactly the 3 ticks at bit phases 7, 8 and 9. Phase 0 is the state right after the tick that carries `tx_bit_start`, and each later tick adds one. `tx_out` is low at every other phase.
- R2: In IR mode, a bit strobed with `tx_nrz`=1 keeps `tx_out` low for the whole bit.
- R3: In IR mode after reset, and before the first bit strobe, `tx_out` is low whatever `tx_nrz` is.
- R4: With `ir_en`=0, `tx_out` equals `tx_nrz` and `rx_nrz` equals `rx_in`, in every cycle and regardless of `rx_invert`.
- R5: In IR mode, a tick that samples the decoded input high makes `rx_nrz` low right after that tick. `rx_nrz` then stays low through the 15 following ticks and returns high on the 16th tick after the last high sample, unless another high sample arrives first.
- R6: With `rx_invert`=1, the decoded input is the complement of `rx_in`, so a low pulse on an otherwise high `rx_in` is what gets detected. With `rx_invert`=0, a high pulse on a low `rx_in` is detected.
- R7: After reset in IR mode, with the receive input idle (no pulse), `rx_nrz` is high.
- R8: A bit strobe that arrives while a pulse is high restarts the phase at 0. The pulse ends at once, and the next pulse, if any, follows the new bit's value and phase.
- R9: Clearing `ir_en` clears the bit phase and the receive hold. After IR mode is enabled again, `tx_out` stays low until the next bit strobe and `rx_nrz` is high until a new high sample.
- R10: If no new bit strobe arrives, the phase stops at 15, and a zero bit produces no second pulse however many further ticks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable, sixteen per bit period |
| ir_en | input | 1 | 1 = IR encode/decode, 0 = NRZ pass-through |
| rx_invert | input | 1 | Inverts the receive input before decoding |
| tx_bit_start | input | 1 | Bit-start strobe from the UART, taken on a tick |
| tx_nrz | input | 1 | UART transmit level for the current bit |
| tx_out | output | 1 | Line-side transmit signal |
| rx_in | input | 1 | Line-side receive signal |
| rx_nrz | output | 1 | Rebuilt NRZ level for the UART receiver |

## Verification
Two functions can act in the same tick. The first is a bit strobe that restarts the transmit phase while the previous zero bit's pulse is still high. The bench provokes this by strobing a one bit at phase 8, then checks that the pulse drops right after that tick and never comes back for the new bit. The second is a receive high sample that lands on the very tick where the hold count would expire. The bench provokes it with pulses spaced exactly one bit period apart and with gaps of 15, 16 and 17 ticks, then checks the output tick by tick against a window computed from the last high sample.

// File: rtl/irsir_pkg.sv
// Package: shared constants and helpers for the infrared SIR codec.
// Assumes a 16x oversampling scheme; all counts are in ticks of that enable.
package irsir_pkg;

    // Default ticks per bit period.
    parameter int unsigned OSR_DEF        = 16;
    // Default first tick phase of the transmit pulse.
    parameter int unsigned PULSE_START_DEF = 7;
    // Default pulse length in ticks.
    parameter int unsigned PULSE_TICKS_DEF = 3;

    // Width of a counter that spans 0 .. osr-1.
    function automatic int unsigned phase_width(input int unsigned osr);
        return (osr > 2) ? $clog2(osr) : 1;
    endfunction

endpackage

// File: rtl/irsir_bit_phase.sv
// Module: irsir_bit_phase
// Counts 16x ticks within the current transmit bit. A bit-start strobe taken
// on a tick loads phase 0 and latches the bit value; later ticks advance the
// phase, which saturates at OSR-1. Assumes start strobes are only meaningful
// together with tick_i. Held cleared while en_i is low.
module irsir_bit_phase #(
    parameter int unsigned OSR  = irsir_pkg::OSR_DEF,
    localparam int unsigned PH_W = irsir_pkg::phase_width(OSR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            tick_i,
    input  logic            start_i,
    input  logic            bit_i,
    output logic [PH_W-1:0] phase_o,
    output logic            bit_o,
    output logic            active_o
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    logic [PH_W-1:0] phase_q;
    logic            bit_q;
    logic            active_q;

    // Phase counter, bit latch and "a bit has begun" flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q  <= '0;
            bit_q    <= 1'b1;
            active_q <= 1'b0;
        end else if (tick_i) begin
            if (start_i) begin
                phase_q  <= '0;
                bit_q    <= bit_i;
                active_q <= 1'b1;
            end else if (active_q && (phase_q != PH_LAST)) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o  = phase_q;
    assign bit_o    = bit_q;
    assign active_o = active_q;

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && start_i) |=> (phase_q == '0 && active_q)) // R8
        else $error("bit start did not restart phase");

    AST_OFF_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (phase_q == '0 && !active_q)) // R9
        else $error("phase not cleared while disabled");

    AST_PHASE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && phase_q == PH_LAST && !start_i) |=> (phase_q == PH_LAST)) // R10
        else $error("phase moved past last tick");

endmodule

// File: rtl/irsir_encoder.sv
// Module: irsir_encoder
// Turns the UART transmit level into short infrared pulses: a zero bit gives
// one high pulse PULSE_TICKS wide starting at phase PULSE_START; a one bit
// gives none. Idles low until the first bit of an IR session. Assumes
// PULSE_START + PULSE_TICKS <= OSR.
module irsir_encoder #(
    parameter int unsigned OSR         = irsir_pkg::OSR_DEF,
    parameter int unsigned PULSE_START = irsir_pkg::PULSE_START_DEF,
    parameter int unsigned PULSE_TICKS = irsir_pkg::PULSE_TICKS_DEF,
    localparam int unsigned PH_W       = irsir_pkg::phase_width(OSR)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic start_i,
    input  logic nrz_i,
    output logic pulse_o
);

    localparam logic [PH_W-1:0] WIN_LO = PH_W'(PULSE_START);
    localparam logic [PH_W-1:0] WIN_HI = PH_W'(PULSE_START + PULSE_TICKS - 1);

    logic [PH_W-1:0] phase;
    logic            cur_bit;
    logic            active;
    logic            in_window;

    irsir_bit_phase #(.OSR(OSR)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .tick_i   (tick_i),
        .start_i  (start_i),
        .bit_i    (nrz_i),
        .phase_o  (phase),
        .bit_o    (cur_bit),
        .active_o (active)
    );

    // Phase window where the pulse may be high.
    always_comb begin
        in_window = (phase >= WIN_LO) && (phase <= WIN_HI);
    end

    // Pulse only for an active zero bit inside the window.
    always_comb begin
        pulse_o = en_i && active && !cur_bit && in_window;
    end

    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(tick_i)) // R1
        else $error("pulse rose without a tick");

    AST_ONE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && start_i && nrz_i) |=> !pulse_o) // R2
        else $error("one bit produced a pulse");

endmodule

// File: rtl/irsir_decoder.sv
// Module: irsir_decoder
// Rebuilds NRZ from infrared pulses. The (optionally inverted) input is
// sampled on each tick; a high sample drives the output low after that tick
// and the low is held until OSR ticks pass with no high sample. Assumes the
// line input is already synchronous to clk. Cleared while en_i is low.
module irsir_decoder #(
    parameter int unsigned OSR  = irsir_pkg::OSR_DEF,
    localparam int unsigned PH_W = irsir_pkg::phase_width(OSR)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic invert_i,
    input  logic line_i,
    output logic low_o
);

    localparam logic [PH_W-1:0] HOLD_LAST = PH_W'(OSR - 1);

    logic            seen;
    logic            low_q;
    logic [PH_W-1:0] hold_q;

    // Polarity correction ahead of detection.
    always_comb begin
        seen = line_i ^ invert_i;
    end

    // Detection latch and hold counter, stepped once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            low_q  <= 1'b0;
            hold_q <= '0;
        end else if (tick_i) begin
            if (seen) begin
                low_q  <= 1'b1;
                hold_q <= '0;
            end else if (low_q) begin
                if (hold_q == HOLD_LAST) begin
                    low_q  <= 1'b0;
                    hold_q <= '0;
                end else begin
                    hold_q <= hold_q + 1'b1;
                end
            end
        end
    end

    assign low_o = low_q;

    AST_DETECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && (line_i ^ invert_i)) |=> low_q) // R5
        else $error("high sample not detected");

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(low_q)) // R5
        else $error("output changed without a tick");

    AST_OFF_CLEARS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> !low_q) // R9
        else $error("hold not cleared while disabled");

endmodule

// File: rtl/irsir_codec.sv
// Module: irsir_codec (top)
// Infrared SIR codec between a UART and an IR transceiver. In IR mode the
// encoder and decoder are used; otherwise both directions pass straight
// through. Assumes tick16 is a one-cycle enable at 16x the bit rate and that
// tx_bit_start coincides with a tick at each bit boundary.
module irsir_codec #(
    parameter int unsigned OSR         = irsir_pkg::OSR_DEF,
    parameter int unsigned PULSE_START = irsir_pkg::PULSE_START_DEF,
    parameter int unsigned PULSE_TICKS = irsir_pkg::PULSE_TICKS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic ir_en,
    input  logic rx_invert,
    input  logic tx_bit_start,
    input  logic tx_nrz,
    output logic tx_out,
    input  logic rx_in,
    output logic rx_nrz
);

    logic ir_pulse;
    logic rx_low;

    irsir_encoder #(
        .OSR         (OSR),
        .PULSE_START (PULSE_START),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ir_en),
        .tick_i  (tick16),
        .start_i (tx_bit_start),
        .nrz_i   (tx_nrz),
        .pulse_o (ir_pulse)
    );

    irsir_decoder #(.OSR(OSR)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ir_en),
        .tick_i   (tick16),
        .invert_i (rx_invert),
        .line_i   (rx_in),
        .low_o    (rx_low)
    );

    // Mode select for both directions.
    always_comb begin
        tx_out = ir_en ? ir_pulse : tx_nrz;
        rx_nrz = ir_en ? !rx_low  : rx_in;
    end

    AST_IR_TX_IDLE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_en && $past(ir_en) && $past(tick16) && $past(tx_bit_start)) |-> !tx_out) // R8
        else $error("pulse high right after a bit start");

endmodule

// File: tb/test_irsir_codec.sv
module test_irsir_codec;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic ir_en = 1'b1;
    logic rx_invert = 1'b0;
    logic tx_bit_start = 1'b0;
    logic tx_nrz = 1'b1;
    logic rx_in = 1'b0;
    logic tx_out;
    logic rx_nrz;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model state.
    int  m_phase = 0;
    bit  m_bit = 1'b1;
    bit  m_active = 1'b0;
    int  t_now = 0;
    int  last_high = -1000;

    always #5 clk = ~clk;

    irsir_codec i_irsir_codec (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .ir_en        (ir_en),
        .rx_invert    (rx_invert),
        .tx_bit_start (tx_bit_start),
        .tx_nrz       (tx_nrz),
        .tx_out       (tx_out),
        .rx_in        (rx_in),
        .rx_nrz       (rx_nrz)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (tick %0d)", req, what, act, exp, t_now);
        end
    endtask

    function automatic bit exp_tx();
        return ir_en && m_active && !m_bit && m_phase >= 7 && m_phase <= 9;
    endfunction

    function automatic bit exp_rx();
        if (!ir_en) return rx_in;
        return !((t_now - last_high) < 16);
    endfunction

    // One 16x tick: drive, clock, update model, check both outputs.
    task automatic tick(input bit start, input bit b, input bit rxv, input string req_tx, input string req_rx);
        @(negedge clk);
        tick16 = 1'b1;
        tx_bit_start = start;
        tx_nrz = b;
        rx_in = rxv;
        @(posedge clk);
        t_now++;
        if (ir_en) begin
            if (start) begin
                m_phase = 0; m_bit = b; m_active = 1'b1;
            end else if (m_active && m_phase < 15) begin
                m_phase++;
            end
            if (rxv ^ rx_invert) last_high = t_now;
        end
        @(negedge clk);
        tick16 = 1'b0;
        tx_bit_start = 1'b0;
        check(req_tx, "tx_out", tx_out, exp_tx());
        check(req_rx, "rx_nrz", rx_nrz, exp_rx());
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic void model_clear();
        m_phase = 0; m_active = 1'b0; m_bit = 1'b1; last_high = -1000;
    endfunction

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 / R7: reset state in IR mode
        tx_nrz = 1'b0;
        @(negedge clk);
        check("R3", "tx idle low after reset", tx_out, 1'b0);
        check("R7", "rx idle high after reset", rx_nrz, 1'b1);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 1'b0, "R3", "R7");

        // R1 / R2 / R10: each bit value, full bit plus extra ticks
        for (int b = 0; b < 2; b++) begin
            tick(1'b1, b[0], 1'b0, b ? "R2" : "R1", "R7");
            for (int k = 1; k < 16; k++) tick(1'b0, b[0], 1'b0, b ? "R2" : "R1", "R7");
            for (int k = 0; k < 12; k++) tick(1'b0, b[0], 1'b0, "R10", "R7");
        end

        // R1 / R2: back-to-back bit pattern 0xA5, LSB first
        for (int i = 0; i < 8; i++) begin
            bit bv = ((8'hA5 >> i) & 1) != 0;
            tick(1'b1, bv, 1'b0, bv ? "R2" : "R1", "R7");
            for (int k = 1; k < 16; k++) tick(1'b0, bv, 1'b0, bv ? "R2" : "R1", "R7");
        end

        // R8: restart strobed while a zero pulse is high (phase 8)
        tick(1'b1, 1'b0, 1'b0, "R8", "R7");
        for (int k = 1; k <= 8; k++) tick(1'b0, 1'b0, 1'b0, "R8", "R7");
        check("R8", "pulse high before restart", tx_out, 1'b1);
        tick(1'b1, 1'b1, 1'b0, "R8", "R7");
        for (int k = 1; k < 16; k++) tick(1'b0, 1'b1, 1'b0, "R8", "R7");
        // restart into a zero bit at phase 9
        tick(1'b1, 1'b0, 1'b0, "R8", "R7");
        for (int k = 1; k <= 9; k++) tick(1'b0, 1'b0, 1'b0, "R8", "R7");
        tick(1'b1, 1'b0, 1'b0, "R8", "R7");
        for (int k = 1; k < 18; k++) tick(1'b0, 1'b0, 1'b0, "R8", "R7");

        // R5 / R6: pulse widths 1..4 and gaps 15..17, both polarities
        for (int inv = 0; inv < 2; inv++) begin
            rx_invert = inv[0];
            for (int k = 0; k < 18; k++) tick(1'b0, 1'b1, inv[0], "R10", "R6");
            for (int w = 1; w <= 4; w++) begin
                for (int g = 15; g <= 17; g++) begin
                    for (int k = 0; k < w; k++) tick(1'b0, 1'b1, ~inv[0], "R10", inv ? "R6" : "R5");
                    for (int k = 0; k < g; k++) tick(1'b0, 1'b1, inv[0], "R10", inv ? "R6" : "R5");
                end
            end
            // pulses exactly one bit apart: output must stay low throughout
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 3; k++) tick(1'b0, 1'b1, ~inv[0], "R10", "R5");
                for (int k = 0; k < 13; k++) tick(1'b0, 1'b1, inv[0], "R10", "R5");
            end
            for (int k = 0; k < 18; k++) tick(1'b0, 1'b1, inv[0], "R10", "R5");
        end
        rx_invert = 1'b0;

        // R4 / R9: disable mid-pulse on both sides, then pass-through sweep
        tick(1'b1, 1'b0, 1'b0, "R1", "R7");
        for (int k = 1; k <= 7; k++) tick(1'b0, 1'b0, 1'b1, "R1", "R5");
        @(negedge clk);
        ir_en = 1'b0;
        model_clear();
        for (int v = 0; v < 8; v++) begin
            rx_invert = v[2];
            tx_nrz = v[0];
            rx_in = v[1];
            tick16 = v[0] ^ v[1];
            @(negedge clk);
            check("R4", "tx pass-through", tx_out, v[0]);
            check("R4", "rx pass-through", rx_nrz, v[1]);
            tick16 = 1'b0;
        end
        for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 1'b1, "R4", "R4");
        rx_invert = 1'b0;
        rx_in = 1'b0;
        tx_nrz = 1'b0;
        @(negedge clk);
        ir_en = 1'b1;
        @(negedge clk);
        check("R9", "tx low after re-enable", tx_out, 1'b0);
        check("R9", "rx high after re-enable", rx_nrz, 1'b1);
        for (int k = 0; k < 10; k++) tick(1'b0, 1'b0, 1'b0, "R9", "R9");
        tick(1'b1, 1'b0, 1'b0, "R9", "R9");
        for (int k = 1; k < 16; k++) tick(1'b0, 1'b0, 1'b0, "R9", "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule